// File: doc/BRIEF.md
# Segment Protection and Address Extension Unit

This block sits between a processor's 32-bit logical address stream and a 36-bit physical memory space. Sixteen programmable segments each cover a naturally aligned power-of-two window, from 4 kB to 4 GB, of the logical space. For every access the unit picks the highest-numbered segment whose window contains the address. It replaces the address bits above the window size with the segment's physical bits and checks the access type and privilege level against the segment's permission bits. An address that no segment covers is refused as if it had no permissions. One fixed logical window is exempt: it passes through untranslated and unchecked.

Refused accesses that are not prefetches are recorded in a fault capture. The capture holds the logical address, the access type and whether the refusal came from a missing segment. It keeps the first fault until software writes the clear location. A fault event pulse marks each new capture. A simple register port writes and reads the segment registers and reads the capture.

Results are registered: an access presented with `acc_valid` in one cycle produces its physical address, grant and no-match flag in the next cycle.

Top module: `segx_unit`

## Requirements
- R1: After reset, segment 0 maps logical 0x00000000–0x7FFFFFFF to the same physical addresses (high bits 35:32 zero) with all six permissions (high register reads 0x0000001E, low register reads 0x0000003F). Segments 1 to 15 read as zero and match nothing.
- R2: A segment with size code c (high register bits 4:0) covers 2^(c+1) bytes, aligned on the base held in high register bits 31:12. It matches only when c is 0x0B or larger; smaller codes disable it.
- R3: For a matching segment, physical bits 35:32 come from low register bits 31:28. Each physical bit k in 12..31 comes from low register bit k-4 when k > c, and from logical bit k otherwise. Bits 11:0 pass through unchanged.
- R4: When several segments match, the highest-numbered one supplies both the translation and the permissions. Lower-numbered matches have no effect.
- R5: The permission field is low register bits 7:0, with bit 0 user execute, bit 1 user write, bit 2 user read, bit 3 supervisor execute, bit 4 supervisor write and bit 5 supervisor read. `acc_kind` is 0 execute, 1 write, 2 read, and 3 is always refused. An access is granted only if its bit is set.
- R6: An address outside every segment (and outside the pass window) gives `out_grant`=0 and `out_nomatch`=1, and records a fault with the no-match bit set.
- R7: Logical addresses 0x08000000–0x0BFFFFFF are always granted, with the physical address equal to the logical address zero-extended, even when a segment covers them.
- R8: A refused access with `acc_prefetch`=1 is still refused but records no fault and raises no fault event.
- R9: Fault capture: `cfg_addr` 32 reads the logical address. `cfg_addr` 33 reads the status: bit 8 = capture valid, bits 5:0 = one-hot access type at the permission bit positions of R5. `cfg_addr` 34 bit 0 reads the no-match bit. The first fault is kept and later faults are ignored, with `fault_evt` high for one cycle per capture. Any write to `cfg_addr` 35 zeroes the capture and re-arms it.
- R10: Segment i's low register is at `cfg_addr` 2i and reads back all 32 written bits. Its high register is at 2i+1 and keeps only bits 31:12 and 4:0, so the other bits read zero.
- R11: `out_valid` is high in exactly the cycle after a cycle with `acc_valid` high. The outputs then belong to that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Logical address |
| acc_kind | input | 2 | 0 execute, 1 write, 2 read, 3 refused |
| acc_super | input | 1 | 1 = supervisor level, 0 = user level |
| acc_prefetch | input | 1 | Access is a prefetch (no fault recorded) |
| out_valid | output | 1 | Result of the previous cycle's access |
| out_paddr | output | 36 | Physical address |
| out_grant | output | 1 | Access allowed |
| out_nomatch | output | 1 | No segment covered the address |
| fault_evt | output | 1 | One-cycle pulse on a new fault capture |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |

## Verification
Each size code from 0 to 31 is tried on one segment at the first and last byte of its window and at the bytes just outside it. This separates correct window width, the disable threshold and the bit-by-bit translation split from an off-by-one in the size decode. A full sweep of the 64 low permission values against all six access types plus the refused type shows that each permission bit gates exactly its own access type. Overlapping segments with conflicting translations and permissions show whether the highest number wins for both. Addresses on either side of the pass window, under a segment with no permissions, show the window edges. A sequence of no-match, permission and prefetch refusals, with clears in between, distinguishes keeping the first capture, re-arming and the silent prefetch path.

// File: rtl/segx_pkg.sv
package segx_pkg;

  localparam int unsigned LA_W   = 32;
  localparam int unsigned PA_W   = 36;
  localparam int unsigned PG_W   = 12;
  localparam int unsigned FR_W   = LA_W - PG_W;     // 20 frame bits
  localparam int unsigned XB_W   = PA_W - PG_W;     // 24 replacement bits
  localparam logic [4:0]  MIN_CODE = 5'h0B;
  localparam logic [5:0]  WIN_TAG  = 6'b000010;     // 0x08000000..0x0BFFFFFF

  typedef struct packed {
    logic [FR_W-1:0] base;
    logic [4:0]      code;
    logic [XB_W-1:0] xbits;
    logic [7:0]      perm;
  } seg_cfg_t;

  typedef enum logic [1:0] {
    KIND_EXEC  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_READ  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  localparam seg_cfg_t SEG_OFF  = '0;
  localparam seg_cfg_t SEG_BOOT = '{base: '0, code: 5'h1E, xbits: '0, perm: 8'h3F};

  // frame bits that belong to the segment (above the window size)
  function automatic logic [FR_W-1:0] keep_mask(input logic [4:0] code);
    logic [FR_W-1:0] m;
    for (int k = 0; k < int'(FR_W); k++) begin
      m[k] = (k + int'(PG_W)) > int'(code);
    end
    return m;
  endfunction

  function automatic logic seg_hit(input seg_cfg_t s, input logic [LA_W-1:0] la);
    logic [FR_W-1:0] m;
    m = keep_mask(s.code);
    return (s.code >= MIN_CODE) && (((la[LA_W-1:PG_W] ^ s.base) & m) == '0);
  endfunction

  function automatic logic [2:0] perm_idx(input logic sup, input logic [1:0] kind);
    return (sup ? 3'd3 : 3'd0) + {1'b0, kind};
  endfunction

endpackage

// File: rtl/segx_regs.sv
module segx_regs #(
  parameter int unsigned NSEG = 16,
  parameter int unsigned CAW  = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [CAW-1:0]                   addr,
  input  logic [31:0]                      wdata,
  output segx_pkg::seg_cfg_t [NSEG-1:0]    segs,
  output logic [31:0]                      rdata
);
  import segx_pkg::*;

  for (genvar i = 0; i < int'(NSEG); i++) begin : g_seg
    seg_cfg_t cur_q, nxt_d;
    logic     wr_lo, wr_hi;

    assign wr_lo = wr_en && (addr == CAW'(2 * i));
    assign wr_hi = wr_en && (addr == CAW'(2 * i + 1));

    always_comb begin
      nxt_d = cur_q;
      if (wr_lo) begin
        nxt_d.xbits = wdata[31:8];
        nxt_d.perm  = wdata[7:0];
      end
      if (wr_hi) begin
        nxt_d.base = wdata[31:12];
        nxt_d.code = wdata[4:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= (i == 0) ? SEG_BOOT : SEG_OFF;
      end else if (wr_lo || wr_hi) begin
        cur_q <= nxt_d;
      end
    end

    assign segs[i] = cur_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < int'(NSEG); i++) begin
      if (addr == CAW'(2 * i)) begin
        rdata = {segs[i].xbits, segs[i].perm};
      end
      if (addr == CAW'(2 * i + 1)) begin
        rdata = {segs[i].base, 7'd0, segs[i].code};
      end
    end
  end

endmodule

// File: rtl/segx_lookup.sv
module segx_lookup #(
  parameter int unsigned NSEG = 16
) (
  input  segx_pkg::seg_cfg_t [NSEG-1:0] segs,
  input  logic [31:0]                   laddr,
  input  logic [1:0]                    kind,
  input  logic                          sup,
  output logic [35:0]                   paddr,
  output logic                          grant,
  output logic                          nomatch
);
  import segx_pkg::*;

  seg_cfg_t        sel;
  logic            hit;
  logic            window;
  logic            allowed;
  logic [FR_W-1:0] m;
  logic [35:0]     xl;

  always_comb begin
    hit = 1'b0;
    sel = SEG_OFF;
    // ascending scan: the last (highest-numbered) hit is kept
    for (int i = 0; i < int'(NSEG); i++) begin
      if (seg_hit(segs[i], laddr)) begin
        hit = 1'b1;
        sel = segs[i];
      end
    end
  end

  always_comb begin
    m       = keep_mask(sel.code);
    xl      = {sel.xbits[XB_W-1:FR_W],
               (sel.xbits[FR_W-1:0] & m) | (laddr[31:PG_W] & ~m),
               laddr[PG_W-1:0]};
    window  = (laddr[31:26] == WIN_TAG);
    allowed = (kind != KIND_RSVD) && sel.perm[perm_idx(sup, kind)];
    grant   = window || (hit && allowed);
    nomatch = !window && !hit;
    paddr   = (window || !hit) ? {4'h0, laddr} : xl;
  end

endmodule

// File: rtl/segx_fault.sv
module segx_fault (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        clr,
  input  logic [31:0] laddr,
  input  logic [1:0]  kind,
  input  logic        sup,
  input  logic        nomatch,
  output logic        evt,
  output logic        held,
  output logic [31:0] far,
  output logic [5:0]  stat,
  output logic        nm
);
  import segx_pkg::*;

  logic        cap;
  logic        held_d, evt_d, nm_d;
  logic [31:0] far_d;
  logic [5:0]  stat_d;

  assign cap = req && !held;

  always_comb begin
    held_d = held;
    far_d  = far;
    stat_d = stat;
    nm_d   = nm;
    evt_d  = cap;
    if (cap) begin
      held_d = 1'b1;
      far_d  = laddr;
      stat_d = (kind == KIND_RSVD) ? 6'd0 : (6'd1 << perm_idx(sup, kind));
      nm_d   = nomatch;
    end else if (clr) begin
      held_d = 1'b0;
      far_d  = '0;
      stat_d = '0;
      nm_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      far  <= '0;
      stat <= '0;
      nm   <= 1'b0;
      evt  <= 1'b0;
    end else begin
      held <= held_d;
      far  <= far_d;
      stat <= stat_d;
      nm   <= nm_d;
      evt  <= evt_d;
    end
  end

  AST_FAULT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R9
  AST_FAULT_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    held && !clr |=> $stable(far) && $stable(nm)); // R9
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat)); // R9
  AST_EVT_SETS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> held); // R9

endmodule

// File: rtl/segx_unit.sv
module segx_unit #(
  parameter int unsigned NSEG = 16,
  localparam int unsigned CAW = $clog2(2 * NSEG + 4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  input  logic [31:0]    acc_addr,
  input  logic [1:0]     acc_kind,
  input  logic           acc_super,
  input  logic           acc_prefetch,
  output logic           out_valid,
  output logic [35:0]    out_paddr,
  output logic           out_grant,
  output logic           out_nomatch,
  output logic           fault_evt,
  input  logic           cfg_wr_en,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata
);
  import segx_pkg::*;

  localparam logic [CAW-1:0] A_FAR = CAW'(2 * NSEG);
  localparam logic [CAW-1:0] A_FSR = CAW'(2 * NSEG + 1);
  localparam logic [CAW-1:0] A_FXR = CAW'(2 * NSEG + 2);
  localparam logic [CAW-1:0] A_CLR = CAW'(2 * NSEG + 3);

  seg_cfg_t [NSEG-1:0] segs;
  logic [31:0]         seg_rdata;
  logic [35:0]         lk_paddr;
  logic                lk_grant, lk_nomatch;
  logic                f_held, f_nm;
  logic [31:0]         f_far;
  logic [5:0]          f_stat;

  segx_regs #(.NSEG(NSEG), .CAW(CAW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .segs  (segs),
    .rdata (seg_rdata)
  );

  segx_lookup #(.NSEG(NSEG)) u_lookup (
    .segs    (segs),
    .laddr   (acc_addr),
    .kind    (acc_kind),
    .sup     (acc_super),
    .paddr   (lk_paddr),
    .grant   (lk_grant),
    .nomatch (lk_nomatch)
  );

  segx_fault u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (acc_valid && !lk_grant && !acc_prefetch),
    .clr     (cfg_wr_en && (cfg_addr == A_CLR)),
    .laddr   (acc_addr),
    .kind    (acc_kind),
    .sup     (acc_super),
    .nomatch (lk_nomatch),
    .evt     (fault_evt),
    .held    (f_held),
    .far     (f_far),
    .stat    (f_stat),
    .nm      (f_nm)
  );

  // result stage: next-state and register processes
  logic [35:0] paddr_d;
  logic        grant_d, nomatch_d;

  always_comb begin
    paddr_d   = out_paddr;
    grant_d   = out_grant;
    nomatch_d = out_nomatch;
    if (acc_valid) begin
      paddr_d   = lk_paddr;
      grant_d   = lk_grant;
      nomatch_d = lk_nomatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_paddr   <= '0;
      out_grant   <= 1'b0;
      out_nomatch <= 1'b0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) begin
        out_paddr   <= paddr_d;
        out_grant   <= grant_d;
        out_nomatch <= nomatch_d;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < A_FAR)       cfg_rdata = seg_rdata;
    else if (cfg_addr == A_FAR) cfg_rdata = f_far;
    else if (cfg_addr == A_FSR) cfg_rdata = {23'd0, f_held, 2'd0, f_stat};
    else if (cfg_addr == A_FXR) cfg_rdata = {31'd0, f_nm};
  end

  AST_NOMATCH_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nomatch |-> !out_grant); // R6
  AST_WINDOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_addr[31:26] == WIN_TAG)
      |=> out_grant && !out_nomatch && (out_paddr == {4'h0, $past(acc_addr)})); // R7
  AST_PREFETCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_prefetch && !cfg_wr_en |=> !fault_evt); // R8
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> out_valid); // R11
  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !out_valid); // R11

endmodule

// File: tb/segx_unit_test.sv
`timescale 1ns/1ps
module segx_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_super, acc_prefetch;
  logic [31:0] acc_addr;
  logic [1:0]  acc_kind;
  logic        out_valid, out_grant, out_nomatch, fault_evt;
  logic [35:0] out_paddr;
  logic        cfg_wr_en;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;

  always #10 clk = ~clk;

  segx_unit uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_super(acc_super), .acc_prefetch(acc_prefetch),
    .out_valid(out_valid), .out_paddr(out_paddr), .out_grant(out_grant),
    .out_nomatch(out_nomatch), .fault_evt(fault_evt),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint unsigned m_base[16], m_code[16], m_x[16], m_perm[16];

  logic [35:0] got_pa;
  logic        got_g, got_nm, got_v, got_evt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 6'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic prog(input int i, input longint unsigned base, input longint unsigned code,
                      input longint unsigned x, input longint unsigned perm);
    cfg_write(2 * i + 1, 32'((base & 64'hFFFFF000) | code));
    cfg_write(2 * i, 32'((x << 8) | perm));
    m_base[i] = base & 64'hFFFFF000; m_code[i] = code; m_x[i] = x; m_perm[i] = perm;
  endtask

  task automatic access(input logic [31:0] a, input int kind, input bit sup, input bit pref);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = 2'(kind);
    acc_super = sup; acc_prefetch = pref;
    @(negedge clk);
    acc_valid = 1'b0; acc_prefetch = 1'b0;
    got_pa = out_paddr; got_g = out_grant; got_nm = out_nomatch;
    got_v = out_valid; got_evt = fault_evt;
  endtask

  task automatic model(input logic [31:0] a, input int kind, input bit sup,
                       output logic [35:0] pa, output bit g, output bit nm);
    int hit_i = -1;
    longint unsigned sz = 0;
    longint unsigned a64 = 64'(a);
    if (a >= 32'h0800_0000 && a <= 32'h0BFF_FFFF) begin
      pa = {4'h0, a}; g = 1'b1; nm = 1'b0;
      return;
    end
    for (int i = 0; i < 16; i++) begin
      if (m_code[i] >= 11) begin
        longint unsigned s = 64'd1 << (m_code[i] + 1);
        if (a64 / s == m_base[i] / s) hit_i = i;
      end
    end
    if (hit_i < 0) begin
      pa = {4'h0, a}; g = 1'b0; nm = 1'b1;
      return;
    end
    sz = 64'd1 << (m_code[hit_i] + 1);
    pa = 36'((((m_x[hit_i] << 12) / sz) * sz) + (a64 % sz));
    nm = 1'b0;
    g  = (kind < 3) && (((m_perm[hit_i] >> ((sup ? 3 : 0) + kind)) & 1) == 1);
  endtask

  task automatic try_one(input logic [31:0] a, input int kind, input bit sup, input string req);
    logic [35:0] epa;
    bit eg, enm;
    access(a, kind, sup, 1'b0);
    model(a, kind, sup, epa, eg, enm);
    chk({got_g, got_nm, got_pa} == {eg, enm, epa} && got_v, req,
        $sformatf("addr=0x%08h kind=%0d sup=%0d {grant,nomatch,paddr}", a, kind, sup),
        {26'd0, got_g, got_nm, got_pa}, {26'd0, eg, enm, epa});
  endtask

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 16; i++) begin
      m_base[i] = 0; m_code[i] = 0; m_x[i] = 0; m_perm[i] = 0;
    end
    m_code[0] = 64'h1E; m_perm[0] = 64'h3F;
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_kind = '0;
    acc_super = 1'b0; acc_prefetch = 1'b0;
    cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents and behaviour
    #1 chk(out_valid == 1'b0 && fault_evt == 1'b0, "R1", "idle outputs", {out_valid, fault_evt}, 0);
    cfg_read(1, rd); chk(rd == 32'h0000001E, "R1", "seg0 high", rd, 32'h1E);
    cfg_read(0, rd); chk(rd == 32'h0000003F, "R1", "seg0 low", rd, 32'h3F);
    for (int i = 2; i < 32; i++) begin
      cfg_read(i, rd); chk(rd == 0, "R1", $sformatf("reg %0d", i), rd, 0);
    end
    try_one(32'h1234_5678, 2, 1'b0, "R1");
    try_one(32'h7FFF_FFFF, 0, 1'b1, "R1");
    try_one(32'h8000_0000, 2, 1'b1, "R1 R6");

    // R10 register field retention
    cfg_write(9, 32'hFFFF_FFFF);
    cfg_read(9, rd); chk(rd == 32'hFFFF_F01F, "R10", "seg4 high", rd, 32'hFFFF_F01F);
    cfg_write(8, 32'h1234_5678);
    cfg_read(8, rd); chk(rd == 32'h1234_5678, "R10", "seg4 low", rd, 32'h1234_5678);
    prog(4, 0, 0, 0, 0);

    // R2 R3 size-code sweep on segment 3
    for (int c = 0; c < 32; c++) begin
      longint unsigned base = (c == 31) ? 64'h0 : (c == 30) ? 64'h8000_0000 : 64'h4000_0000;
      longint unsigned sz = 64'd1 << (c + 1);
      prog(3, base, longint'(c), 64'hABCDEF, 64'h3F);
      try_one(32'(base), 2, 1'b1, "R2 R3");
      try_one(32'(base + sz - 1), 2, 1'b1, "R2 R3");
      try_one(32'(base + sz), 2, 1'b1, "R2 R3");
      try_one(32'(base - 1), 2, 1'b1, "R2 R3");
    end

    // R4 overlap priority
    prog(3, 64'hC000_0000, 64'h1D, 64'h111111, 64'h3F);
    prog(5, 64'hC010_0000, 64'h0B, 64'h333333, 64'h3F);
    prog(7, 64'hC010_0000, 64'h13, 64'h222222, 64'h24);
    try_one(32'hC010_0010, 2, 1'b0, "R4");
    try_one(32'hC010_0010, 1, 1'b0, "R4");
    try_one(32'hC01F_FFFF, 2, 1'b1, "R4");
    try_one(32'hC020_0000, 1, 1'b0, "R4");
    prog(7, 0, 0, 0, 0);
    try_one(32'hC010_0010, 1, 1'b0, "R4");
    prog(5, 0, 0, 0, 0);
    prog(3, 0, 0, 0, 0);

    // R5 permission sweep
    for (int p = 0; p < 64; p++) begin
      prog(2, 64'h9000_0000, 64'h0B, 64'h000123, longint'(p));
      for (int k = 0; k < 4; k++) begin
        try_one(32'h9000_0ABC, k, 1'b0, "R5");
        try_one(32'h9000_0ABC, k, 1'b1, "R5");
      end
    end

    // R7 pass window under a segment with no permissions
    prog(9, 64'h0800_0000, 64'h1A, 64'hFFFFFF, 64'h00);
    for (int k = 0; k < 3; k++) begin
      try_one(32'h0800_0000, k, 1'b0, "R7");
      try_one(32'h0BFF_FFFF, k, 1'b0, "R7");
      try_one(32'h0C00_0000, k, 1'b0, "R7");
      try_one(32'h07FF_FFFF, k, 1'b0, "R7");
    end
    prog(9, 0, 0, 0, 0);

    // R9 R6 fault capture
    cfg_write(35, 32'h0);
    cfg_read(33, rd); chk(rd == 0, "R9", "status after clear", rd, 0);
    access(32'hF000_0010, 1, 1'b0, 1'b0);
    chk(got_g == 1'b0 && got_nm == 1'b1, "R6", "nomatch outputs", {got_g, got_nm}, 2'b01);
    chk(got_evt == 1'b1, "R9", "event on first fault", got_evt, 1);
    @(negedge clk); #1 chk(fault_evt == 1'b0, "R9", "event one cycle", fault_evt, 0);
    chk(out_valid == 1'b0, "R11", "valid drops when idle", out_valid, 0);
    cfg_read(32, rd); chk(rd == 32'hF000_0010, "R9", "fault addr", rd, 32'hF000_0010);
    cfg_read(33, rd); chk(rd == 32'h102, "R9", "fault status", rd, 32'h102);
    cfg_read(34, rd); chk(rd == 32'h1, "R6", "no-match bit", rd, 1);
    prog(2, 64'h9000_0000, 64'h0B, 64'h000123, 64'h00);
    access(32'h9000_0ABC, 0, 1'b1, 1'b0);
    chk(got_evt == 1'b0 && got_g == 1'b0, "R9", "second fault ignored", {got_evt, got_g}, 0);
    cfg_read(32, rd); chk(rd == 32'hF000_0010, "R9", "first fault kept", rd, 32'hF000_0010);
    cfg_write(35, 32'h5);
    cfg_read(33, rd); chk(rd == 0, "R9", "status cleared", rd, 0);
    access(32'h9000_0ABC, 0, 1'b1, 1'b0);
    chk(got_evt == 1'b1, "R9", "event after re-arm", got_evt, 1);
    cfg_read(32, rd); chk(rd == 32'h9000_0ABC, "R9", "new fault addr", rd, 32'h9000_0ABC);
    cfg_read(33, rd); chk(rd == 32'h108, "R9", "new fault status", rd, 32'h108);
    cfg_read(34, rd); chk(rd == 32'h0, "R9", "permission fault no-match bit", rd, 0);
    cfg_write(35, 32'h0);

    // R8 prefetch refusal is silent
    access(32'hF000_0010, 2, 1'b0, 1'b1);
    chk(got_g == 1'b0 && got_nm == 1'b1, "R8", "prefetch refused", {got_g, got_nm}, 2'b01);
    chk(got_evt == 1'b0, "R8", "no event for prefetch", got_evt, 0);
    cfg_read(33, rd); chk(rd == 0, "R8", "no capture for prefetch", rd, 0);
    access(32'h9000_0ABC, 1, 1'b0, 1'b1);
    chk(got_evt == 1'b0, "R8", "no event for prefetch perm refusal", got_evt, 0);
    cfg_read(32, rd); chk(rd == 0, "R8", "fault addr untouched", rd, 0);

    // R11 latency
    access(32'h0000_1000, 2, 1'b0, 1'b0);
    chk(got_v == 1'b1, "R11", "valid one cycle after access", got_v, 1);
    @(negedge clk); #1 chk(out_valid == 1'b0, "R11", "valid single cycle", out_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule